// File: doc/BRIEF.md
# Serial-to-Register-Bus Access Bridge

This block is an SPI target that turns short byte-framed serial transactions into single reads and writes on an internal parallel register bus. The bus is synchronous to the system clock. The serial lines are sampled through a two-flop synchronizer and edge-detected in the system clock domain, so the serial clock must run several times slower than the system clock. Each frame opens with a command byte that selects a block, a subblock and the direction. A register byte follows it, and then a 32-bit data word moves in one direction or the other.

Writes and reads use frames of different lengths. A write frame carries the two command bytes and then the data word. A read frame carries the two command bytes and two padding bytes. During the padding bytes the target fetches the word, and it then shifts the word back out. Every block/subblock pair is checked against a fixed, sparse validity map before any bus strobe goes out. A pair outside the map produces no bus activity. Raising chip select at any point ends the frame without an access.

Top module: `spi_regbus_bridge`

## Requirements
- R1: The serial side runs in SPI mode 0 with 8-bit bytes sent most significant bit first. MOSI is sampled on the rising edge of the serial clock.
- R2: In the first byte of a frame, bits 7:5 are the block number, bit 4 is the direction (1 = write, 0 = read) and bits 3:0 are the subblock number. The second byte is the register address. These values appear on busBlock, busSub and busReg whenever a strobe is high.
- R3: A write frame is the command byte, the register byte and four data bytes, most significant first. After the sixth byte completes, busWrEn pulses for exactly one clock with the full word on busWdata.
- R4: A read frame is the command byte, the register byte and two padding bytes whose content is ignored. busRdEn pulses for one clock after the second byte. busRdata must hold the word from the cycle after that pulse until the fourth byte ends. The word is then returned on MISO over the next four bytes, most significant bit first, and MISO changes only after falling serial-clock edges.
- R5: The valid pairs are: block 1 with subblock 0, 1, 2, 3, 4 or 6; blocks 3, 4 and 5 with subblock 0 or 1; blocks 2 and 7 with subblock 0 only. Every other pair, including all of block 0 and block 6, is invalid.
- R6: An access to an invalid pair raises neither strobe. Its write data is dropped, and a read returns 32 zero bits on MISO.
- R7: Raising chip select in the middle of a frame, even in the middle of a byte, aborts it with no bus strobe. The next frame is then decoded from its first bit.
- R8: MISO is held low while chip select is high, even when the serial clock toggles.
- R9: A frame raises at most one strobe. Bytes clocked in after the end of a write frame have no effect.
- R10: After reset both strobes are low and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSclk | input | 1 | Serial clock, idle low |
| spiMosi | input | 1 | Serial data into the target |
| spiCsN | input | 1 | Active-low chip select |
| spiMiso | output | 1 | Serial data out of the target |
| busBlock | output | 3 | Block number of the access |
| busSub | output | 4 | Subblock number of the access |
| busReg | output | 8 | Register address of the access |
| busWdata | output | 32 | Write data word |
| busWrEn | output | 1 | One-cycle write strobe |
| busRdEn | output | 1 | One-cycle read strobe |
| busRdata | input | 32 | Read data returned by the register bus |

## Verification
The bench reads every block with subblocks 0 to 7, plus subblock 15 on block 1, and so walks the whole validity map. A decoder that let a neighbouring pair through would show up as an unexpected strobe. A wrong read for an invalid pair would return the bus word instead of zeros. Frames are also cut off after three whole bytes and after four bits, and each is followed by a normal write. A byte counter that survived an abort would misplace that next write or never strobe it. A write frame padded with trailing bytes must still strobe once. Read words with distinct bytes catch a returned word that is shifted by one bit because of a wrong turnaround edge, and they also catch byte-order faults.

// File: rtl/spi_regbus_pkg.sv
package spi_regbus_pkg;

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic clearFrame;  // chip select high: drop frame state
    logic sampleBit;   // rising serial edge: shift MOSI in
    logic latchCmd;    // first byte complete
    logic latchReg;    // second byte complete
    logic pushData;    // a write data byte complete
    logic loadTx;      // turnaround falling edge: load the return word
    logic txFromBus;   // load bus data (valid pair) or zeros
    logic shiftTx;     // falling serial edge: advance MISO
  } dpCtrl_t;

  // Sparse map of addressable block/subblock pairs
  function automatic logic isValidPair(input logic [2:0] blk, input logic [3:0] sub);
    case (blk)
      3'd1:             isValidPair = (sub <= 4'd4) || (sub == 4'd6);
      3'd3, 3'd4, 3'd5: isValidPair = (sub <= 4'd1);
      3'd2, 3'd7:       isValidPair = (sub == 4'd0);
      default:          isValidPair = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spi_regbus_sync.sv
module spi_regbus_sync #(
  parameter int               WIDTH     = 3,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= RESET_VAL;
    else       pipe[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= RESET_VAL;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/spi_regbus_ctrl.sv
module spi_regbus_ctrl
  import spi_regbus_pkg::*;
#(
  parameter int PAD_BYTES  = 2,
  parameter int DATA_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkS,
  input  logic       csnS,
  input  logic [7:0] cmdByte,
  output dpCtrl_t    dpCtl,
  output logic       busWrEn,
  output logic       busRdEn
);

  localparam int FRAME_BYTES = 2 + PAD_BYTES + DATA_BYTES;
  localparam int CNT_W       = $clog2(FRAME_BYTES + 1);
  localparam logic [CNT_W-1:0] IDX_CMD   = '0;
  localparam logic [CNT_W-1:0] IDX_REG   = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX_TURN  = CNT_W'(1 + PAD_BYTES);
  localparam logic [CNT_W-1:0] IDX_WLAST = CNT_W'(1 + DATA_BYTES);
  localparam logic [CNT_W-1:0] IDX_SAT   = CNT_W'(FRAME_BYTES);

  logic             sclkPrev;
  logic [2:0]       bitCnt;
  logic [CNT_W-1:0] byteCnt;
  logic             loadPending;
  logic             sclkRise, sclkFall, byteDone;
  logic             cmdWrite, pairOk;

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign byteDone = sclkRise & ~csnS & (bitCnt == 3'd7);
  assign cmdWrite = cmdByte[4];
  assign pairOk   = isValidPair(cmdByte[7:5], cmdByte[3:0]);

  always_comb begin
    dpCtl            = '0;
    dpCtl.clearFrame = csnS;
    dpCtl.sampleBit  = sclkRise & ~csnS;
    dpCtl.latchCmd   = byteDone && (byteCnt == IDX_CMD);
    dpCtl.latchReg   = byteDone && (byteCnt == IDX_REG);
    dpCtl.pushData   = byteDone && cmdWrite && (byteCnt > IDX_REG) && (byteCnt <= IDX_WLAST);
    dpCtl.loadTx     = sclkFall & ~csnS & loadPending;
    dpCtl.txFromBus  = pairOk;
    dpCtl.shiftTx    = sclkFall & ~csnS & ~loadPending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev    <= 1'b0;
      bitCnt      <= '0;
      byteCnt     <= '0;
      loadPending <= 1'b0;
      busWrEn     <= 1'b0;
      busRdEn     <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      busWrEn  <= byteDone && (byteCnt == IDX_WLAST) && cmdWrite && pairOk;
      busRdEn  <= byteDone && (byteCnt == IDX_REG) && !cmdWrite && pairOk;
      if (csnS) begin
        bitCnt      <= '0;
        byteCnt     <= '0;
        loadPending <= 1'b0;
      end else begin
        if (sclkRise) bitCnt <= bitCnt + 3'd1;
        if (byteDone && byteCnt != IDX_SAT) byteCnt <= byteCnt + CNT_W'(1);
        if (byteDone && byteCnt == IDX_TURN && !cmdWrite) loadPending <= 1'b1;
        else if (sclkFall)                                loadPending <= 1'b0;
      end
    end
  end

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busRdEn));
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> !busWrEn);
  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> !busRdEn);
  assert_rd_dir_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |-> !cmdByte[4]);
  assert_map_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn || busRdEn) |-> isValidPair(cmdByte[7:5], cmdByte[3:0]));
  assert_abort_R7: assert property (@(posedge clk) disable iff (!rstN)
    csnS |=> (byteCnt == '0 && bitCnt == '0 && !loadPending));

endmodule

// File: rtl/spi_regbus_dp.sv
module spi_regbus_dp
  import spi_regbus_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  localparam int DATA_W    = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mosiS,
  input  logic              csnS,
  input  dpCtrl_t           dpCtl,
  input  logic [DATA_W-1:0] busRdata,
  output logic [7:0]        cmdByte,
  output logic [7:0]        regByte,
  output logic [DATA_W-1:0] wdata,
  output logic              miso
);

  logic [6:0]        rxShift;
  logic [7:0]        newByte;
  logic [DATA_W-1:0] txShift;

  assign newByte = {rxShift, mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      cmdByte <= '0;
      regByte <= '0;
      wdata   <= '0;
    end else begin
      if (dpCtl.sampleBit) rxShift <= newByte[6:0];
      if (dpCtl.latchCmd)  cmdByte <= newByte;
      if (dpCtl.latchReg)  regByte <= newByte;
      if (dpCtl.pushData)  wdata   <= {wdata[DATA_W-9:0], newByte};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 txShift <= '0;
    else if (dpCtl.clearFrame) txShift <= '0;
    else if (dpCtl.loadTx)     txShift <= dpCtl.txFromBus ? busRdata : '0;
    else if (dpCtl.shiftTx)    txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  assign miso = ~csnS & txShift[DATA_W-1];

  assert_tx_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    csnS |=> (txShift == '0));
  assert_tx_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtl.loadTx && !dpCtl.shiftTx && !csnS) |=> $stable(txShift));

endmodule

// File: rtl/spi_regbus_bridge.sv
module spi_regbus_bridge
  import spi_regbus_pkg::*;
#(
  parameter int PAD_BYTES   = 2,
  parameter int DATA_BYTES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    spiSclk,
  input  logic                    spiMosi,
  input  logic                    spiCsN,
  output logic                    spiMiso,
  output logic [2:0]              busBlock,
  output logic [3:0]              busSub,
  output logic [7:0]              busReg,
  output logic [8*DATA_BYTES-1:0] busWdata,
  output logic                    busWrEn,
  output logic                    busRdEn,
  input  logic [8*DATA_BYTES-1:0] busRdata
);

  logic       sclkS, mosiS, csnS;
  logic [7:0] cmdByte;
  dpCtrl_t    dpCtl;

  spi_regbus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) sync_i (
    .clk(clk), .rstN(rstN),
    .asyncIn({spiCsN, spiSclk, spiMosi}),
    .syncOut({csnS, sclkS, mosiS})
  );

  spi_regbus_ctrl #(.PAD_BYTES(PAD_BYTES), .DATA_BYTES(DATA_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclkS(sclkS), .csnS(csnS), .cmdByte(cmdByte),
    .dpCtl(dpCtl), .busWrEn(busWrEn), .busRdEn(busRdEn)
  );

  spi_regbus_dp #(.DATA_BYTES(DATA_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .mosiS(mosiS), .csnS(csnS), .dpCtl(dpCtl),
    .busRdata(busRdata), .cmdByte(cmdByte), .regByte(busReg),
    .wdata(busWdata), .miso(spiMiso)
  );

  assign busBlock = cmdByte[7:5];
  assign busSub   = cmdByte[3:0];

endmodule

// File: tb/spi_regbus_bridge_tb.sv
module spi_regbus_bridge_tb_top;

  localparam int HALF     = 6;       // system clocks per serial half-period
  localparam int WATCHDOG = 190000;

  typedef struct {
    bit          isWrite;
    logic [2:0]  blk;
    logic [3:0]  sub;
    logic [7:0]  rg;
    logic [31:0] data;
  } busItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic miso, busWrEn, busRdEn;
  logic [2:0] busBlock;
  logic [3:0] busSub;
  logic [7:0] busReg;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;

  int nChecks = 0;
  int nFails  = 0;
  busItem_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  spi_regbus_bridge dut_i (
    .clk(clk), .rstN(rstN), .spiSclk(sclk), .spiMosi(mosi), .spiCsN(csn),
    .spiMiso(miso), .busBlock(busBlock), .busSub(busSub), .busReg(busReg),
    .busWdata(busWdata), .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdata(busRdata)
  );

  function automatic bit tbValid(input logic [2:0] b, input logic [3:0] s);
    if (b == 3'd1) return (s < 4'd5) || (s == 4'd6);
    if (b == 3'd2 || b == 3'd7) return s == 4'd0;
    if (b >= 3'd3 && b <= 3'd5) return s < 4'd2;
    return 1'b0;
  endfunction

  function automatic logic [31:0] modelWord(input logic [2:0] b, input logic [3:0] s, input logic [7:0] r);
    return {5'b10101, b, s, 4'h9, r, r ^ 8'hC3};
  endfunction

  // register bus model: returns a word that depends on the address
  always @(posedge clk) if (busRdEn) busRdata <= modelWord(busBlock, busSub, busReg);

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && (busWrEn || busRdEn)) begin
      check(!(busWrEn && busRdEn), "R9 both strobes", {busWrEn, busRdEn}, 0);
      if (expQ.size() == 0) begin
        check(1'b0, "R6/R7/R9 unexpected strobe", {busBlock, busSub, busReg}, 0);
      end else begin
        busItem_t it;
        it = expQ.pop_front();
        check(busWrEn == it.isWrite, "R2 direction", busWrEn, it.isWrite);
        check({busBlock, busSub, busReg} == {it.blk, it.sub, it.rg}, "R2 address",
              {busBlock, busSub, busReg}, {it.blk, it.sub, it.rg});
        if (it.isWrite) check(busWdata == it.data, "R1/R3 write data", busWdata, it.data);
      end
    end
  end

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx, input int nBits = 8);
    rx = '0;
    for (int i = 7; i > 7 - nBits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      rx[i] = miso;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic startFrame();
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic endFrame(input string tag);
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (3 * HALF) @(negedge clk);
    check(expQ.size() == 0, {tag, " strobe count"}, expQ.size(), 0);
    check(miso == 1'b0, "R8 miso after frame", miso, 0);
  endtask

  task automatic doWrite(input logic [2:0] b, input logic [3:0] s, input logic [7:0] r,
                         input logic [31:0] d, input int extra, input string tag);
    logic [7:0] rx;
    if (tbValid(b, s)) expQ.push_back('{1'b1, b, s, r, d});
    startFrame();
    spiByte({b, 1'b1, s}, rx);
    spiByte(r, rx);
    for (int i = 3; i >= 0; i--) spiByte(d[i*8 +: 8], rx);
    for (int i = 0; i < extra; i++) spiByte(8'hFF, rx);
    endFrame(tag);
  endtask

  task automatic doRead(input logic [2:0] b, input logic [3:0] s, input logic [7:0] r,
                        input logic [7:0] pad, input string tag);
    logic [7:0] rx;
    logic [31:0] got, exp;
    exp = tbValid(b, s) ? modelWord(b, s, r) : 32'h0;
    if (tbValid(b, s)) expQ.push_back('{1'b0, b, s, r, 32'h0});
    startFrame();
    spiByte({b, 1'b0, s}, rx);
    spiByte(r, rx);
    spiByte(pad, rx);
    spiByte(pad, rx);
    for (int i = 3; i >= 0; i--) begin
      spiByte(8'h00, rx);
      got[i*8 +: 8] = rx;
    end
    check(got == exp, {tag, " read word"}, got, exp);
    endFrame(tag);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stimulus
    logic [7:0] rx;
    repeat (5) @(negedge clk);
    check(miso == 1'b0 && !busWrEn && !busRdEn, "R10 reset outputs", {miso, busWrEn, busRdEn}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(miso == 1'b0 && !busWrEn && !busRdEn, "R10 after reset", {miso, busWrEn, busRdEn}, 0);

    // basic write and read-back style accesses
    doWrite(3'd1, 4'd6, 8'h19, 32'h1234_5678, 0, "R3 write b1s6");
    doWrite(3'd7, 4'd0, 8'h05, 32'h8000_0001, 0, "R1/R3 write b7s0");
    doRead (3'd1, 4'd6, 8'h19, 8'h00, "R4 read b1s6");
    doRead (3'd3, 4'd1, 8'hA7, 8'hFF, "R4 read with nonzero padding");

    // invalid pairs
    doWrite(3'd1, 4'd5, 8'h00, 32'hDEAD_BEEF, 0, "R6 write invalid b1s5");
    doWrite(3'd0, 4'd0, 8'h11, 32'hCAFE_F00D, 0, "R6 write invalid b0s0");
    doRead (3'd6, 4'd0, 8'h22, 8'h00, "R6 read invalid b6s0");

    // validity map sweep
    for (int b = 0; b < 8; b++)
      for (int s = 0; s < 8; s++)
        doRead(3'(b), 4'(s), 8'(b * 16 + s), 8'h00, "R5 map sweep");
    doRead(3'd1, 4'd15, 8'h3C, 8'h00, "R5 b1s15");

    // abort after three full bytes, then a normal write
    startFrame();
    spiByte({3'd1, 1'b1, 4'd0}, rx);
    spiByte(8'h40, rx);
    spiByte(8'hAA, rx);
    endFrame("R7 abort after bytes");
    doWrite(3'd4, 4'd1, 8'h77, 32'h0F1E_2D3C, 0, "R7 write after abort");

    // abort in the middle of a byte, then a normal read
    startFrame();
    spiByte({3'd2, 1'b1, 4'd0}, rx);
    spiByte(8'h01, rx, 4);
    endFrame("R7 abort mid byte");
    doRead(3'd2, 4'd0, 8'h01, 8'h00, "R7 read after abort");

    // trailing bytes after a write frame
    doWrite(3'd5, 4'd0, 8'hEE, 32'hA5A5_5A5A, 3, "R9 write with trailing bytes");

    // serial clock toggling with chip select high
    csn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      mosi = i[0];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      check(miso == 1'b0, "R8 miso idle", miso, 0);
      sclk = 1'b0;
    end
    repeat (3 * HALF) @(negedge clk);
    check(expQ.size() == 0 && !busWrEn && !busRdEn, "R8 no access while deselected", expQ.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule